// File: doc/BRIEF.md
# Conditional Relative Branch Evaluator

This block makes the taken/not-taken decision for the short relative branches of an 8-bit processor core. When a request is strobed, it takes the branch opcode, the 5-bit status word, the 6-bit indirect scratchpad pointer, the signed displacement byte and the program counter value that points at that displacement byte. One clock later it returns four results: whether the opcode belongs to a branch group, whether the branch is taken, the program counter to continue from, and the number of cycles the sequencer should spend on the instruction.

The block decodes three kinds of branch. In the branch-on-true group, a 3-bit mask held in the opcode selects status flags, and the branch is taken when any selected flag is set. In the branch-on-false group, a 4-bit opcode mask selects flags, and the branch is taken when none of the selected flags is set. The pointer branch is taken unless the pointer's three low bits are all ones. Any other opcode passes through as a non-branch: the program counter is unchanged and the cycle count is zero.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is held, and after it is released with no request, res_valid, res_hit and res_taken are 0, and res_pc and res_cycles are 0.
- R2: res_valid is 1 in the cycle after a cycle with req_valid high, and 0 in the cycle after a cycle with req_valid low.
- R3: For opcodes 0x80 to 0x87, res_hit is 1. The branch is taken exactly when (status[2:0] AND opcode[2:0]) is nonzero. Status bit 0 is sign, bit 1 is carry and bit 2 is zero.
- R4: For opcodes 0x90 to 0x9F, res_hit is 1. The branch is taken exactly when (status[3:0] AND opcode[3:0]) is zero. Status bit 3 is overflow.
- R5: Opcode 0x80 is never taken and opcode 0x90 is always taken, whatever the status value.
- R6: Opcode 0x8F is taken exactly when pointer bits [2:0] are not 3'b111. Pointer bits [5:3] have no effect on the decision.
- R7: Status bit 4, the interrupt-control flag, has no effect on any branch decision.
- R8: A taken branch gives res_pc = req_pc + the displacement sign-extended to 16 bits, wrapping modulo 2^16.
- R9: A branch opcode that is not taken gives res_pc = req_pc + 1, wrapping modulo 2^16, which skips the displacement byte.
- R10: res_cycles is 5 for a taken branch and 3 for a branch opcode that is not taken.
- R11: Any other opcode gives res_hit = 0, res_taken = 0, res_pc = req_pc and res_cycles = 0.
- R12: In a cycle with req_valid low, res_pc, res_taken, res_hit and res_cycles keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Strobe: evaluate the request inputs in this cycle |
| req_opcode | input | 8 | Fetched opcode |
| req_status | input | 5 | Status word: sign, carry, zero, overflow, interrupt-control (bits 0 to 4) |
| req_isp | input | 6 | Indirect scratchpad pointer |
| req_disp | input | 8 | Signed displacement byte |
| req_pc | input | 16 | Program counter value that points at the displacement byte |
| res_valid | output | 1 | The results below were updated by the previous strobe |
| res_hit | output | 1 | The opcode belongs to one of the branch groups |
| res_taken | output | 1 | The branch is taken |
| res_pc | output | 16 | Program counter to continue from |
| res_cycles | output | 4 | Cycle count for the sequencer |

## Verification
The assertions assume that req_valid stays low until the internal two-stage reset release has completed. A strobe inside that window would be lost, while the properties, which are gated only by the external reset, would still expect a result. The stimulus therefore waits several clocks after reset is deasserted before the first strobe. It also separates strobes with an idle cycle, so that the hold behaviour and the dropping of res_valid are both exercised. Request inputs change only on the falling clock edge, which keeps the sampled values unambiguous for the one-cycle-back comparisons in the properties.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  localparam int OPC_W      = 8;
  localparam int STAT_W     = 5;
  localparam int COND_W     = 4;
  localparam int PTR_W      = 6;
  localparam int PTR_LOW_W  = 3;

  // opcode group prefixes
  localparam logic [4:0] OPC_TRUE_PFX  = 5'b10000;  // 0x80..0x87
  localparam logic [3:0] OPC_FALSE_PFX = 4'b1001;   // 0x90..0x9F
  localparam logic [7:0] OPC_PTR       = 8'h8F;

  localparam logic [PTR_W-1:0] PTR_LOW_MASK = PTR_W'((1 << PTR_LOW_W) - 1);

  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_TRUE  = 2'd1,
    BK_FALSE = 2'd2,
    BK_PTR   = 2'd3
  } br_kind_e;

endpackage

// File: rtl/rbu_decode.sv
module rbu_decode
  import rbu_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  output br_kind_e          kind,
  output logic [COND_W-1:0] mask
);

  always_comb begin
    kind = BK_NONE;
    mask = '0;
    if (opcode[7:3] == OPC_TRUE_PFX) begin
      kind = BK_TRUE;
      mask = {1'b0, opcode[2:0]};
    end else if (opcode[7:4] == OPC_FALSE_PFX) begin
      kind = BK_FALSE;
      mask = opcode[3:0];
    end else if (opcode == OPC_PTR) begin
      kind = BK_PTR;
    end
  end

endmodule

// File: rtl/rbu_cond.sv
module rbu_cond
  import rbu_pkg::*;
(
  input  br_kind_e          kind,
  input  logic [COND_W-1:0] mask,
  input  logic [STAT_W-1:0] status,
  input  logic [PTR_W-1:0]  isp,
  output logic              taken
);

  logic [STAT_W-1:0] mask_w;
  logic [STAT_W-1:0] sel;
  logic              any_sel;
  logic              low_all_ones;

  // the interrupt-control bit never enters the mask
  assign mask_w = STAT_W'(mask);

  for (genvar i = 0; i < STAT_W; i++) begin : g_sel
    assign sel[i] = status[i] & mask_w[i];
  end

  assign any_sel      = |sel;
  assign low_all_ones = &(isp | ~PTR_LOW_MASK);

  always_comb begin
    unique case (kind)
      BK_TRUE:  taken = any_sel;
      BK_FALSE: taken = ~any_sel;
      BK_PTR:   taken = ~low_all_ones;
      default:  taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/rbu_target.sv
module rbu_target #(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int CYC_W     = 4,
  parameter int CYC_TAKEN = 5,
  parameter int CYC_SKIP  = 3
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              hit,
  input  logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [CYC_W-1:0]  cycles
);

  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] pc_jump;
  logic [PC_W-1:0] pc_skip;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign pc_jump  = pc + disp_ext;
  assign pc_skip  = pc + PC_W'(1);

  always_comb begin
    if (!hit) begin
      next_pc = pc;
      cycles  = '0;
    end else if (taken) begin
      next_pc = pc_jump;
      cycles  = CYC_W'(CYC_TAKEN);
    end else begin
      next_pc = pc_skip;
      cycles  = CYC_W'(CYC_SKIP);
    end
  end

endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int CYC_W     = 4,
  parameter int CYC_TAKEN = 5,
  parameter int CYC_SKIP  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OPC_W-1:0]  req_opcode,
  input  logic [STAT_W-1:0] req_status,
  input  logic [PTR_W-1:0]  req_isp,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [PC_W-1:0]   req_pc,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_taken,
  output logic [PC_W-1:0]   res_pc,
  output logic [CYC_W-1:0]  res_cycles
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  br_kind_e          kind;
  logic [COND_W-1:0] mask;
  logic              cond_taken;
  logic              cur_hit;
  logic [PC_W-1:0]   cur_pc;
  logic [CYC_W-1:0]  cur_cycles;

  rbu_decode u_decode (
    .opcode (req_opcode),
    .kind   (kind),
    .mask   (mask)
  );

  rbu_cond u_cond (
    .kind   (kind),
    .mask   (mask),
    .status (req_status),
    .isp    (req_isp),
    .taken  (cond_taken)
  );

  assign cur_hit = (kind != BK_NONE);

  rbu_target #(
    .PC_W      (PC_W),
    .DISP_W    (DISP_W),
    .CYC_W     (CYC_W),
    .CYC_TAKEN (CYC_TAKEN),
    .CYC_SKIP  (CYC_SKIP)
  ) u_target (
    .pc      (req_pc),
    .disp    (req_disp),
    .hit     (cur_hit),
    .taken   (cond_taken),
    .next_pc (cur_pc),
    .cycles  (cur_cycles)
  );

  // next state
  logic             valid_d, hit_d, taken_d;
  logic [PC_W-1:0]  pc_d;
  logic [CYC_W-1:0] cyc_d;
  logic             load_en;

  assign load_en = req_valid;

  always_comb begin
    valid_d = req_valid;
    hit_d   = res_hit;
    taken_d = res_taken;
    pc_d    = res_pc;
    cyc_d   = res_cycles;
    if (load_en) begin
      hit_d   = cur_hit;
      taken_d = cond_taken;
      pc_d    = cur_pc;
      cyc_d   = cur_cycles;
    end
  end

  // registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_taken  <= 1'b0;
      res_pc     <= '0;
      res_cycles <= '0;
    end else begin
      res_valid  <= valid_d;
      res_hit    <= hit_d;
      res_taken  <= taken_d;
      res_pc     <= pc_d;
      res_cycles <= cyc_d;
    end
  end

endmodule

// File: rtl/rbu_checker.sv
module rbu_checker
  import rbu_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int CYC_W     = 4,
  parameter int CYC_TAKEN = 5,
  parameter int CYC_SKIP  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OPC_W-1:0]  req_opcode,
  input logic [STAT_W-1:0] req_status,
  input logic [PTR_W-1:0]  req_isp,
  input logic [DISP_W-1:0] req_disp,
  input logic [PC_W-1:0]   req_pc,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_taken,
  input logic [PC_W-1:0]   res_pc,
  input logic [CYC_W-1:0]  res_cycles
);

  logic [PC_W-1:0] disp_sx;
  assign disp_sx = {{(PC_W-DISP_W){req_disp[DISP_W-1]}}, req_disp};

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_true_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_opcode[7:3] == OPC_TRUE_PFX) |=>
      (res_hit && res_taken == (($past(req_status[2:0]) & $past(req_opcode[2:0])) != 3'd0)));

  assert_false_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_opcode[7:4] == OPC_FALSE_PFX) |=>
      (res_hit && res_taken == (($past(req_status[3:0]) & $past(req_opcode[3:0])) == 4'd0)));

  assert_ptr_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_opcode == OPC_PTR) |=>
      (res_hit && res_taken == ($past(req_isp[2:0]) != 3'b111)));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |-> res_pc == $past(req_pc) + $past(disp_sx));

  assert_skip_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && !res_taken) |-> res_pc == $past(req_pc) + PC_W'(1));

  assert_cycle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |->
      res_cycles == (res_taken ? CYC_W'(CYC_TAKEN) : CYC_W'(CYC_SKIP)));

  assert_non_branch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |->
      (!res_taken && res_pc == $past(req_pc) && res_cycles == '0));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_pc) && $stable(res_taken) &&
                    $stable(res_hit) && $stable(res_cycles)));

endmodule

bind rel_branch_unit rbu_checker #(
  .PC_W      (PC_W),
  .DISP_W    (DISP_W),
  .CYC_W     (CYC_W),
  .CYC_TAKEN (CYC_TAKEN),
  .CYC_SKIP  (CYC_SKIP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_opcode (req_opcode),
  .req_status (req_status),
  .req_isp    (req_isp),
  .req_disp   (req_disp),
  .req_pc     (req_pc),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_taken  (res_taken),
  .res_pc     (res_pc),
  .res_cycles (res_cycles)
);

// File: tb/sim_rel_branch_unit.sv
module sim_rel_branch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 11;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_opcode;
  logic [4:0]  req_status;
  logic [5:0]  req_isp;
  logic [7:0]  req_disp;
  logic [15:0] req_pc;
  logic        res_valid;
  logic        res_hit;
  logic        res_taken;
  logic [15:0] res_pc;
  logic [3:0]  res_cycles;

  int n_tests;
  int n_fail;
  bit done;

  rel_branch_unit u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_opcode (req_opcode),
    .req_status (req_status),
    .req_isp    (req_isp),
    .req_disp   (req_disp),
    .req_pc     (req_pc),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_taken  (res_taken),
    .res_pc     (res_pc),
    .res_cycles (res_cycles)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // fields: opcode, status, isp, disp, pc | hit, taken, pc, cycles
  localparam logic [64:0] TBL [N_VEC] = '{
    {8'h81, 5'h01, 6'h00, 8'h10, 16'h1000, 1'b1, 1'b1, 16'h1010, 4'd5}, // R3 sign set
    {8'h82, 5'h01, 6'h00, 8'h10, 16'h1000, 1'b1, 1'b0, 16'h1001, 4'd3}, // R3 carry clear
    {8'h94, 5'h04, 6'h00, 8'hF0, 16'h2000, 1'b1, 1'b0, 16'h2001, 4'd3}, // R4 zero set
    {8'h94, 5'h00, 6'h00, 8'hF0, 16'h2000, 1'b1, 1'b1, 16'h1FF0, 4'd5}, // R4/R8 backward
    {8'h8F, 5'h00, 6'h07, 8'h05, 16'h3000, 1'b1, 1'b0, 16'h3001, 4'd3}, // R6 all ones
    {8'h8F, 5'h00, 6'h3B, 8'h05, 16'h3000, 1'b1, 1'b1, 16'h3005, 4'd5}, // R6 low 011
    {8'h9F, 5'h10, 6'h00, 8'h7F, 16'h4000, 1'b1, 1'b1, 16'h407F, 4'd5}, // R7 irq bit only
    {8'h12, 5'h1F, 6'h00, 8'h33, 16'h5000, 1'b0, 1'b0, 16'h5000, 4'd0}, // R11 other opcode
    {8'h90, 5'h0F, 6'h00, 8'h80, 16'h0010, 1'b1, 1'b1, 16'hFF90, 4'd5}, // R5/R8 wrap down
    {8'h80, 5'h1F, 6'h00, 8'h02, 16'h6000, 1'b1, 1'b0, 16'h6001, 4'd3}, // R5 never
    {8'h87, 5'h04, 6'h00, 8'h01, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 4'd5}  // R8 wrap up
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [4:0] st, input logic [5:0] isp,
                       input logic [7:0] disp, input logic [15:0] pc);
    @(negedge clk);
    req_valid  = 1'b1;
    req_opcode = op;
    req_status = st;
    req_isp    = isp;
    req_disp   = disp;
    req_pc     = pc;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  function automatic bit ref_taken(input logic [7:0] op, input logic [4:0] st,
                                   input logic [5:0] isp);
    if (op[7:3] == 5'b10000) return (st[2:0] & op[2:0]) != 3'd0;
    if (op[7:4] == 4'b1001)  return (st[3:0] & op[3:0]) == 4'd0;
    if (op == 8'h8F)         return isp[2:0] != 3'b111;
    return 1'b0;
  endfunction

  function automatic logic [15:0] ref_pc(input bit tk, input logic [7:0] disp,
                                         input logic [15:0] pc);
    return tk ? pc + {{8{disp[7]}}, disp} : pc + 16'd1;
  endfunction

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0;
    req_opcode = '0; req_status = '0; req_isp = '0; req_disp = '0; req_pc = '0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check(!res_valid && !res_hit && !res_taken && res_pc == 16'd0 && res_cycles == 4'd0,
          "R1 in reset", {res_valid, res_taken, res_cycles}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!res_valid && !res_taken && res_pc == 16'd0, "R1 after release",
          {res_valid, res_taken, res_pc}, 0);

    // table walk
    for (int i = 0; i < N_VEC; i++) begin
      apply(TBL[i][64:57], TBL[i][56:52], TBL[i][51:46], TBL[i][45:38], TBL[i][37:22]);
      check(res_valid == 1'b1, "R2 valid after strobe", res_valid, 1);
      check(res_hit == TBL[i][21], "R11 hit", res_hit, TBL[i][21]);
      check(res_taken == TBL[i][20], "R3/R4/R5/R6/R7 table taken", res_taken, TBL[i][20]);
      check(res_pc == TBL[i][19:4], "R8/R9/R11 table pc", res_pc, TBL[i][19:4]);
      check(res_cycles == TBL[i][3:0], "R10 table cycles", res_cycles, TBL[i][3:0]);
    end

    // R12 hold and R2 drop: last entry was taken to 0x0000
    @(negedge clk);
    check(res_valid == 1'b0, "R2 valid drops", res_valid, 0);
    check(res_pc == 16'h0000 && res_taken && res_cycles == 4'd5 && res_hit,
          "R12 hold", {res_taken, res_pc}, {1'b1, 16'h0000});

    // sweep both polarities over every status value
    for (int op = 8'h80; op <= 8'h9F; op++) begin
      if (op >= 8'h88 && op <= 8'h8F) continue;
      for (int st = 0; st < 32; st++) begin
        bit tk;
        tk = ref_taken(8'(op), 5'(st), 6'h00);
        apply(8'(op), 5'(st), 6'h00, 8'hFE, 16'h8000);
        check(res_taken == tk, (op < 8'h90) ? "R3 sweep" : "R4 sweep", res_taken, tk);
        check(res_pc == ref_pc(tk, 8'hFE, 16'h8000), "R8/R9 sweep pc", res_pc,
              ref_pc(tk, 8'hFE, 16'h8000));
        if (op == 8'h80) check(!res_taken, "R5 0x80 sweep", res_taken, 0);
        if (op == 8'h90) check(res_taken, "R5 0x90 sweep", res_taken, 1);
      end
    end

    // R7: toggling bit 4 never changes the decision
    for (int op = 8'h90; op <= 8'h9F; op++) begin
      apply(8'(op), 5'h10, 6'h00, 8'h01, 16'h0100);
      check(res_taken == ref_taken(8'(op), 5'h00, 6'h00), "R7 irq bit", res_taken,
            ref_taken(8'(op), 5'h00, 6'h00));
    end

    // R6: every pointer value
    for (int p = 0; p < 64; p++) begin
      bit tk;
      tk = (p % 8) != 7;
      apply(8'h8F, 5'h1F, 6'(p), 8'h20, 16'h0200);
      check(res_taken == tk, "R6 pointer sweep", res_taken, tk);
      check(res_cycles == (tk ? 4'd5 : 4'd3), "R10 pointer cycles", res_cycles,
            tk ? 4'd5 : 4'd3);
    end

    // R11: neighbours of the branch groups
    apply(8'h88, 5'h1F, 6'h00, 8'h44, 16'h0777);
    check(!res_hit && !res_taken && res_pc == 16'h0777 && res_cycles == 4'd0,
          "R11 opcode 0x88", res_pc, 16'h0777);
    apply(8'hA0, 5'h00, 6'h00, 8'h44, 16'h0999);
    check(!res_hit && !res_taken && res_pc == 16'h0999, "R11 opcode 0xA0", res_pc, 16'h0999);

    // R1 again: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!res_valid && !res_hit && res_pc == 16'd0 && res_cycles == 4'd0,
          "R1 re-reset", res_pc, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule